// File: doc/BRIEF.md
# Codec Sample Rate Tick Generator

This block paces a multimedia codec port. It takes one of three source ticks, divides it by 32 times a 7-bit divisor, and produces a sample clock with a 50% duty cycle. At the start of every sample period it pulses a transfer strobe. The strobe tells the transmit FIFO logic to move the next sample into the data field of the serial shifter.

Software arms and disarms the block with a register write. The request is held until the next rising edge of frame sync, and only then is it applied. Each source input is a single-cycle enable pulse that is synchronous to `clk`. The two internal rates are chosen by one select bit. The external source first passes through its own programmable prescaler. When a strobe fires while the FIFO reports empty, a sticky underrun flag is set. Software clears it by writing a 1.

Top module: `codec_rate_gen`

## Requirements
- R1: After reset, `running`, `xfer_strobe`, `sample_clk` and `underrun` are all 0. The divisor resets to 4, and the selected source is internal source 0.
- R2: A write to address 3'b100 with bit 14 or bit 15 set arms the block. `running` rises one cycle after the next `fsync` rising edge. With no `fsync` edge, `running` does not change.
- R3: A write to address 3'b100 with bits 14 and 15 both clear disarms the block at the next `fsync` rising edge. While `running` is 0, `xfer_strobe` and `sample_clk` stay 0.
- R4: `xfer_strobe` is high in the same cycle in which `running` first reads 1. An arming write applied while already running causes no strobe and does not restart the period.
- R5: While running, `xfer_strobe` pulses once every 32×D selected source ticks, where D is the divisor in use.
- R6: `sample_clk` is high for the first 16×D source ticks of each period and low for the remaining 16×D.
- R7: The divisor is bits [6:0] of address 3'b010. Values 0 to 3 act as 4.
- R8: A divisor write made while running takes effect at the next strobe and never shortens or lengthens the current period.
- R9: At address 3'b010, bit 8 selects the external source and bit 7 selects internal source 1 over internal source 0. External ticks are divided by (bits [12:9] + 1).
- R10: `underrun` becomes 1 in the cycle after a strobe that coincides with `fifo_empty` high. It stays 1 until a write of 1 to bit 0 of address 3'b110 clears it. If a set and a clear fall in the same cycle, the set wins.
- R11: A later enable write replaces an unapplied earlier one. A write made in the same cycle as an `fsync` rising edge waits for the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Register write data |
| fsync | input | 1 | Frame sync level |
| tick_int0 | input | 1 | Internal source 0 enable pulse |
| tick_int1 | input | 1 | Internal source 1 enable pulse |
| tick_ext | input | 1 | External source enable pulse |
| fifo_empty | input | 1 | Transmit FIFO empty |
| sample_clk | output | 1 | 50% duty sample clock |
| xfer_strobe | output | 1 | One-cycle load strobe to FIFO logic |
| running | output | 1 | Block is enabled |
| underrun | output | 1 | Sticky strobe-on-empty flag |

## Verification
A wrong prescaler or modulus counter shows at the ports as a strobe interval that differs from 32×D ticks. It also shows as a `sample_clk` edge that moves away from the half-period point, and both appear within one sample period. A wrong pending-request state shows as `running` changing on the wrong `fsync` edge, or changing with no edge at all, within a cycle of that edge. The reference model is compared against every output on every cycle, so any of these faults is reported in the cycle it first becomes visible.

// File: rtl/crg_pkg.sv
package crg_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 16;
  localparam int DIV_W   = 7;
  localparam int PRE_W   = 5;
  localparam int EXT_W   = 4;
  localparam int DIV_MIN = 4;

  localparam logic [ADDR_W-1:0] ADDR_RUN  = 3'b100;
  localparam logic [ADDR_W-1:0] ADDR_RATE = 3'b010;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'b110;

  localparam int BIT_IN_EN   = 14;
  localparam int BIT_OUT_EN  = 15;
  localparam int BIT_INT_SEL = 7;
  localparam int BIT_USE_EXT = 8;
  localparam int BIT_EXT_LO  = 9;
  localparam int BIT_UND_CLR = 0;
endpackage

// File: rtl/crg_src_sel.sv
module crg_src_sel #(
  parameter int EXT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_int0,
  input  logic             tick_int1,
  input  logic             tick_ext,
  input  logic             use_ext,
  input  logic             int_sel,
  input  logic [EXT_W-1:0] ext_pre,
  output logic             src_tick
);
  logic [EXT_W-1:0] ecnt_q, ecnt_d;
  logic             ext_wrap;

  assign ext_wrap = tick_ext && (ecnt_q == ext_pre);

  always_comb begin
    ecnt_d = ecnt_q;
    if (tick_ext) ecnt_d = ext_wrap ? '0 : ecnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecnt_q <= '0;
    else        ecnt_q <= ecnt_d;
  end

  assign src_tick = use_ext ? ext_wrap : (int_sel ? tick_int1 : tick_int0);
endmodule

// File: rtl/crg_arm_ctrl.sv
module crg_arm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_run,
  input  logic wr_on,
  input  logic fsync,
  output logic start,
  output logic count_en,
  output logic running
);
  logic fs_q, pend_v_q, pend_on_q, run_q;
  logic pend_v_d, pend_on_d, run_d, rise, stop;

  assign rise  = fsync && !fs_q;
  assign start = rise && pend_v_q && pend_on_q && !run_q;
  assign stop  = rise && pend_v_q && !pend_on_q;

  always_comb begin
    pend_v_d  = pend_v_q;
    pend_on_d = pend_on_q;
    run_d     = run_q;
    if (rise) pend_v_d = 1'b0;
    if (wr_run) begin
      pend_v_d  = 1'b1;
      pend_on_d = wr_on;
    end
    if (start)     run_d = 1'b1;
    else if (stop) run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q      <= 1'b0;
      pend_v_q  <= 1'b0;
      pend_on_q <= 1'b0;
      run_q     <= 1'b0;
    end else begin
      fs_q      <= fsync;
      pend_v_q  <= pend_v_d;
      pend_on_q <= pend_on_d;
      run_q     <= run_d;
    end
  end

  assign count_en = run_q && !stop;
  assign running  = run_q;
endmodule

// File: rtl/crg_rate_div.sv
module crg_rate_div #(
  parameter int DIV_W   = 7,
  parameter int PRE_W   = 5,
  parameter int DIV_MIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             count_en,
  input  logic             running,
  input  logic             src_tick,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             xfer_strobe,
  output logic             sample_clk
);
  localparam int PH_W = DIV_W + PRE_W;

  logic [PRE_W-1:0] presc_q, presc_d;
  logic [DIV_W-1:0] cnt_q, cnt_d, act_q, act_d, div_eff, done;
  logic             stb_q, stb_d, ptick;
  logic [PH_W-1:0]  elapsed, half;

  assign div_eff = (div_cfg < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : div_cfg;
  assign ptick   = count_en && src_tick && (presc_q == {PRE_W{1'b1}});

  always_comb begin
    presc_d = presc_q;
    cnt_d   = cnt_q;
    act_d   = act_q;
    stb_d   = 1'b0;
    if (start) begin
      presc_d = '0;
      cnt_d   = div_eff - 1'b1;
      act_d   = div_eff;
      stb_d   = 1'b1;
    end else if (count_en && src_tick) begin
      presc_d = presc_q + 1'b1;
      if (ptick) begin
        if (cnt_q == '0) begin
          cnt_d = div_eff - 1'b1;
          act_d = div_eff;
          stb_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      cnt_q   <= '0;
      act_q   <= DIV_W'(DIV_MIN);
      stb_q   <= 1'b0;
    end else begin
      presc_q <= presc_d;
      cnt_q   <= cnt_d;
      act_q   <= act_d;
      stb_q   <= stb_d;
    end
  end

  assign done        = act_q - 1'b1 - cnt_q;
  assign elapsed     = {done, presc_q};
  assign half        = {1'b0, act_q, {(PRE_W-1){1'b0}}};
  assign sample_clk  = running && (elapsed < half);
  assign xfer_strobe = stb_q;
endmodule

// File: rtl/codec_rate_gen.sv
module codec_rate_gen
  import crg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              fsync,
  input  logic              tick_int0,
  input  logic              tick_int1,
  input  logic              tick_ext,
  input  logic              fifo_empty,
  output logic              sample_clk,
  output logic              xfer_strobe,
  output logic              running,
  output logic              underrun
);
  logic             wr_run, wr_rate, wr_stat, wr_on;
  logic [DIV_W-1:0] div_q, div_d;
  logic             isel_q, isel_d, uext_q, uext_d, und_q, und_d;
  logic [EXT_W-1:0] pre_q, pre_d;
  logic             src_tick, start, count_en;

  assign wr_run  = cfg_we && (cfg_addr == ADDR_RUN);
  assign wr_rate = cfg_we && (cfg_addr == ADDR_RATE);
  assign wr_stat = cfg_we && (cfg_addr == ADDR_STAT);
  assign wr_on   = cfg_wdata[BIT_IN_EN] || cfg_wdata[BIT_OUT_EN];

  always_comb begin
    div_d  = div_q;
    isel_d = isel_q;
    uext_d = uext_q;
    pre_d  = pre_q;
    und_d  = und_q;
    if (wr_rate) begin
      div_d  = cfg_wdata[DIV_W-1:0];
      isel_d = cfg_wdata[BIT_INT_SEL];
      uext_d = cfg_wdata[BIT_USE_EXT];
      pre_d  = cfg_wdata[BIT_EXT_LO +: EXT_W];
    end
    if (xfer_strobe && fifo_empty)         und_d = 1'b1;
    else if (wr_stat && cfg_wdata[BIT_UND_CLR]) und_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_W'(DIV_MIN);
      isel_q <= 1'b0;
      uext_q <= 1'b0;
      pre_q  <= '0;
      und_q  <= 1'b0;
    end else begin
      div_q  <= div_d;
      isel_q <= isel_d;
      uext_q <= uext_d;
      pre_q  <= pre_d;
      und_q  <= und_d;
    end
  end

  crg_src_sel #(.EXT_W(EXT_W)) u_src (
    .clk(clk), .rst_n(rst_n), .tick_int0(tick_int0), .tick_int1(tick_int1),
    .tick_ext(tick_ext), .use_ext(uext_q), .int_sel(isel_q), .ext_pre(pre_q),
    .src_tick(src_tick)
  );

  crg_arm_ctrl u_arm (
    .clk(clk), .rst_n(rst_n), .wr_run(wr_run), .wr_on(wr_on), .fsync(fsync),
    .start(start), .count_en(count_en), .running(running)
  );

  crg_rate_div #(.DIV_W(DIV_W), .PRE_W(PRE_W), .DIV_MIN(DIV_MIN)) u_div (
    .clk(clk), .rst_n(rst_n), .start(start), .count_en(count_en),
    .running(running), .src_tick(src_tick), .div_cfg(div_q),
    .xfer_strobe(xfer_strobe), .sample_clk(sample_clk)
  );

  assign underrun = und_q;
endmodule

// File: rtl/crg_chk.sv
module crg_chk (
  input logic clk,
  input logic rst_n,
  input logic fsync,
  input logic fifo_empty,
  input logic running,
  input logic xfer_strobe,
  input logic sample_clk,
  input logic underrun
);
  // R2
  run_on_fsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(running) |-> ($past(fsync) && !$past(fsync, 2)));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!xfer_strobe && !sample_clk));

  // R4
  start_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> xfer_strobe);

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_strobe |=> !xfer_strobe);

  // R6
  clk_rise_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_clk) |-> xfer_strobe);

  // R10
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_strobe && fifo_empty) |=> underrun);
endmodule

bind codec_rate_gen crg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .fifo_empty(fifo_empty),
  .running(running), .xfer_strobe(xfer_strobe), .sample_clk(sample_clk),
  .underrun(underrun)
);

// File: tb/codec_rate_gen_tb.sv
module codec_rate_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        fsync = 1'b0;
  logic        tick_int0, tick_int1, tick_ext;
  logic        fifo_empty = 1'b0;
  logic        sample_clk, xfer_strobe, running, underrun;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign tick_int0 = 1'b1;
  assign tick_int1 = cyc[0];
  assign tick_ext  = 1'b1;

  codec_rate_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .fsync(fsync), .tick_int0(tick_int0),
    .tick_int1(tick_int1), .tick_ext(tick_ext), .fifo_empty(fifo_empty),
    .sample_clk(sample_clk), .xfer_strobe(xfer_strobe), .running(running),
    .underrun(underrun)
  );

  // reference model state
  bit m_run, m_pv, m_pon, m_fsq, m_stb, m_und, m_isel, m_ext;
  int m_phase, m_D, m_div, m_pre, m_ecnt;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_run = 0; m_pv = 0; m_pon = 0; m_fsq = 0; m_stb = 0; m_und = 0;
      m_isel = 0; m_ext = 0; m_phase = 0; m_D = 4; m_div = 4; m_pre = 0; m_ecnt = 0;
    end else begin
      bit rise, et, t, nstb, nund;
      int eff;
      rise = fsync && !m_fsq;
      m_fsq = fsync;
      et = tick_ext && (m_ecnt == m_pre);
      if (tick_ext) m_ecnt = (m_ecnt == m_pre) ? 0 : m_ecnt + 1;
      t = m_ext ? et : (m_isel ? tick_int1 : tick_int0);
      eff = (m_div < 4) ? 4 : m_div;
      if (m_stb && fifo_empty) nund = 1;
      else if (cfg_we && cfg_addr == 3'b110 && cfg_wdata[0]) nund = 0;
      else nund = m_und;
      nstb = 0;
      if (rise && m_pv && m_pon && !m_run) begin
        m_run = 1; m_phase = 0; m_D = eff; nstb = 1;
      end else if (rise && m_pv && !m_pon) begin
        m_run = 0;
      end else if (m_run && t) begin
        m_phase++;
        if (m_phase == 32 * m_D) begin
          m_phase = 0; m_D = eff; nstb = 1;
        end
      end
      if (rise) m_pv = 0;
      if (cfg_we && cfg_addr == 3'b100) begin
        m_pv = 1; m_pon = cfg_wdata[14] | cfg_wdata[15];
      end
      if (cfg_we && cfg_addr == 3'b010) begin
        m_div = cfg_wdata[6:0]; m_isel = cfg_wdata[7];
        m_ext = cfg_wdata[8]; m_pre = cfg_wdata[12:9];
      end
      m_stb = nstb;
      m_und = nund;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit msc;
      msc = m_run && (m_phase < 16 * m_D);
      chk(running === m_run, "R2 running vs model", running, m_run);
      chk(xfer_strobe === m_stb, "R5 xfer_strobe vs model", xfer_strobe, m_stb);
      chk(sample_clk === msc, "R6 sample_clk vs model", sample_clk, msc);
      chk(underrun === m_und, "R10 underrun vs model", underrun, m_und);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_fs();
    @(negedge clk); fsync = 1;
    @(negedge clk); fsync = 0;
  endtask

  task automatic wait_stb(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!xfer_strobe && n < 5000);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n, h;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(running == 0 && xfer_strobe == 0, "R1 reset run/strobe", running, 0);
    chk(sample_clk == 0 && underrun == 0, "R1 reset clk/underrun", sample_clk, 0);

    // R2 arming waits for fsync
    wr(3'b010, 16'd5);
    wr(3'b100, 16'h4000);
    repeat (20) @(negedge clk);
    chk(running == 0, "R2 no fsync no start", running, 0);
    pulse_fs();
    // R4 strobe on enable
    chk(running == 1, "R2 running after fsync", running, 1);
    chk(xfer_strobe == 1, "R4 strobe at enable", xfer_strobe, 1);

    // R5 period and R6 duty with D=5
    wait_stb(n);
    chk(n == 160, "R5 period D=5", n, 160);
    h = sample_clk;
    for (int i = 1; i < 160; i++) begin @(negedge clk); h += sample_clk; end
    chk(h == 80, "R6 high count D=5", h, 80);

    // R8 divisor change applies at the next reload
    wait_stb(n);
    wr(3'b010, 16'd6);
    wait_stb(n);
    chk(n + 2 == 160, "R8 current period kept", n + 2, 160);
    wait_stb(n);
    chk(n == 192, "R8 new period D=6", n, 192);

    // R7 clamp of small divisors
    wr(3'b010, 16'd2);
    wait_stb(n);
    wait_stb(n);
    chk(n == 128, "R7 divisor 2 clamps to 4", n, 128);

    // R9 source selection
    wr(3'b010, 16'h0084);
    wait_stb(n); wait_stb(n);
    chk(n == 256, "R9 internal source 1", n, 256);
    wr(3'b010, 16'h0504);
    wait_stb(n); wait_stb(n);
    chk(n == 384, "R9 external prescale 3", n, 384);
    wr(3'b010, 16'h0004);
    wait_stb(n);

    // R10 underrun sticky and clear
    fifo_empty = 1;
    wait_stb(n);
    @(negedge clk);
    fifo_empty = 0;
    chk(underrun == 1, "R10 underrun set", underrun, 1);
    repeat (10) @(negedge clk);
    chk(underrun == 1, "R10 underrun sticky", underrun, 1);
    wr(3'b110, 16'h0001);
    chk(underrun == 0, "R10 underrun cleared", underrun, 0);

    // R11 later write replaces pending
    wr(3'b100, 16'h0000);
    wr(3'b100, 16'h8000);
    pulse_fs();
    chk(running == 1, "R11 replaced request keeps run", running, 1);
    // R4 arming while running: no restart strobe
    wr(3'b100, 16'hC000);
    pulse_fs();
    chk(xfer_strobe == 0 || m_stb == 1, "R4 no strobe on re-arm", xfer_strobe, m_stb);

    // R11 write in same cycle as fsync edge waits
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'b100; cfg_wdata = 16'h0000; fsync = 1;
    @(negedge clk);
    cfg_we = 0; fsync = 0;
    chk(running == 1, "R11 same-cycle write deferred", running, 1);
    pulse_fs();
    // R3 disarm
    chk(running == 0, "R3 stopped at fsync", running, 0);
    h = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); h += sample_clk + xfer_strobe;
    end
    chk(h == 0, "R3 idle outputs quiet", h, 0);

    // R2 restart after stop
    wr(3'b100, 16'h4000);
    pulse_fs();
    chk(running == 1 && xfer_strobe == 1, "R2 restart with strobe", running, 1);
    wait_stb(n);
    chk(n == 128, "R5 period D=4", n, 128);

    finish_run();
  end
endmodule